// File: doc/BRIEF.md
# Intra-Tile Layer Stage Sequencer

This block controls the work done on one tile of a layer combo. A combo has one key layer (convolution, pooling or fully connected) and optional affiliated layers. Every tile follows one fixed stage order. A set of per-combo select flags, held in configuration registers, removes the stages that a given combo does not use.

The sequencer starts each enabled stage engine with a one-cycle strobe. It then waits for that engine's done signal and moves on to the next enabled stage. A disabled stage costs no cycles. Every tile begins by loading the input and weight buffers from DRAM and ends by writing the results back. The affiliated stages work on the key stage's result in on-chip storage, so no DRAM traffic happens between the key stage and the write-back.

A build-time mask marks the layer types that the network lacks, and the flags of those types are held at "no". A tile whose flags select no key layer is reported as a configuration error. Such a tile completes at once, without any stage strobe. The arithmetic inside each stage is handled elsewhere.

Top module: `tile_stage_seq`

## Requirements
- R1: A `tile_start` while idle with a valid key flag raises `busy` and pulses `stage_go[0]` (input load) in the next cycle.
- R2: Exactly one key stage runs per tile, chosen by priority: convolution (flag bit 0, strobe bit 1), then pooling (flag bit 1, strobe bit 2), then fully connected (flag bit 2, strobe bit 3).
- R3: After the key stage, the optional stages run in this order, each only when its flag is set: batch-norm and scale (flag bit 3, strobe bit 4), then ReLU (flag bit 4, strobe bit 5), then element-wise add (flag bit 5, strobe bit 6).
- R4: Every valid tile ends with the output-buffer write (strobe bit 7) and then the DRAM write-back (strobe bit 8). One cycle after the write-back's done is seen, `tile_done` pulses for one cycle and `busy` falls.
- R5: Stage strobes last one cycle, and at most one is high at a time. The sequencer stays in the current stage until that stage's own `stage_done` bit is set. Done bits of other stages are ignored.
- R6: The next enabled stage's strobe appears in the cycle right after the current stage's done, so a skipped stage costs no cycles.
- R7: A `tile_start` while idle with none of flag bits 0..2 set gives `tile_done` and `cfg_err` together in the next cycle, with no stage strobe and without raising `busy`.
- R8: A flag whose bit is clear in parameter `LAYER_PRESENT` is treated as "no". With pooling absent, a pooling-only tile is a configuration error, and a pooling-plus-fully-connected tile runs fully connected.
- R9: The flags are captured at `tile_start`. Later changes to `sel_flags`, and any `tile_start` while busy, have no effect on the running tile.
- R10: After reset, `busy`, `tile_done`, `cfg_err` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_start | input | 1 | Start pulse for one tile |
| sel_flags | input | 6 | Per-combo select flags: conv, pool, FC, bnorm, ReLU, eltwise (bits 0..5) |
| stage_done | input | 9 | Done signal from each stage engine, one bit per stage |
| stage_go | output | 9 | One-cycle start strobe for each stage |
| busy | output | 1 | A tile is in progress |
| tile_done | output | 1 | One-cycle pulse when a tile completes |
| cfg_err | output | 1 | Pulses with `tile_done` when the flags select no key stage |

## Verification
The assertions check on every cycle that at most one strobe is high and that no strobe repeats in the next cycle. They also check that the sequencer stays put while no done bit is set and that an idle block issues no strobes. Finally, they check the start and error responses one cycle after a start, and that `busy` never falls without `tile_done`.

Only the bench's scenarios can show the complete stage order for each flag combination. The bench sweeps all 64 flag settings. It injects done bits from the wrong stages, extra start pulses and changed flags in the middle of a tile. A second instance with pooling absent covers the build-time mask.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
   localparam int NFLAG  = 6;
   localparam int NSTG   = 9;
   localparam int SW     = $clog2(NSTG);
   // flag bit positions
   localparam int F_CONV = 0;
   localparam int F_POOL = 1;
   localparam int F_FC   = 2;
   localparam int F_BN   = 3;
   localparam int F_RELU = 4;
   localparam int F_ELTW = 5;
   // stage positions, in execution order
   localparam int S_LOAD  = 0;
   localparam int S_CONV  = 1;
   localparam int S_POOL  = 2;
   localparam int S_FC    = 3;
   localparam int S_BN    = 4;
   localparam int S_RELU  = 5;
   localparam int S_ELTW  = 6;
   localparam int S_OBUF  = 7;
   localparam int S_WBACK = 8;
   typedef logic [SW-1:0]    stg_idx_t;
   typedef logic [NSTG-1:0]  stg_vec_t;
   typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/tseq_flag_mask.sv
module tseq_flag_mask
   import tseq_pkg::*;
#(
   parameter logic [NFLAG-1:0] LAYER_PRESENT = '1
) (
   input  flag_vec_t flags_in,
   output flag_vec_t flags_out,
   output logic      key_ok
);
   for (genvar i = 0; i < NFLAG; i++) begin : g_bit
      if (LAYER_PRESENT[i]) begin : g_keep
         assign flags_out[i] = flags_in[i];
      end else begin : g_tie
         assign flags_out[i] = 1'b0;
      end
   end
   assign key_ok = flags_out[F_CONV] | flags_out[F_POOL] | flags_out[F_FC];
endmodule

// File: rtl/tseq_stage_enable.sv
module tseq_stage_enable
   import tseq_pkg::*;
(
   input  flag_vec_t flags,
   output stg_vec_t  en
);
   always_comb begin
      en          = '0;
      en[S_LOAD]  = 1'b1;
      en[S_CONV]  = flags[F_CONV];
      en[S_POOL]  = flags[F_POOL] & ~flags[F_CONV];
      en[S_FC]    = flags[F_FC] & ~flags[F_CONV] & ~flags[F_POOL];
      en[S_BN]    = flags[F_BN];
      en[S_RELU]  = flags[F_RELU];
      en[S_ELTW]  = flags[F_ELTW];
      en[S_OBUF]  = 1'b1;
      en[S_WBACK] = 1'b1;
   end
endmodule

// File: rtl/tseq_next_pick.sv
module tseq_next_pick #(
   parameter int N  = 9,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  en,
   input  logic [IW-1:0] cur,
   output logic [IW-1:0] nxt,
   output logic          has_next
);
   always_comb begin
      nxt      = '0;
      has_next = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (en[i] && (i > int'(cur))) begin
            nxt      = IW'(i);
            has_next = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tile_stage_seq.sv
module tile_stage_seq
   import tseq_pkg::*;
#(
   parameter logic [5:0] LAYER_PRESENT = 6'b111111
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tile_start,
   input  logic [5:0] sel_flags,
   input  logic [8:0] stage_done,
   output logic [8:0] stage_go,
   output logic       busy,
   output logic       tile_done,
   output logic       cfg_err
);
   if (LAYER_PRESENT[2:0] == 3'b000) begin : g_bad_cfg
      $error("tile_stage_seq: LAYER_PRESENT must keep at least one key layer");
   end

   flag_vec_t live_m, flags_q;
   logic      live_key_ok;
   stg_vec_t  en;
   stg_idx_t  cur_q, nxt;
   logic      has_next;
   stg_vec_t  go_q;
   logic      busy_q, done_q, err_q;

   tseq_flag_mask #(.LAYER_PRESENT(LAYER_PRESENT)) u_mask (
      .flags_in (sel_flags),
      .flags_out(live_m),
      .key_ok   (live_key_ok)
   );

   tseq_stage_enable u_en (
      .flags(flags_q),
      .en   (en)
   );

   tseq_next_pick #(.N(NSTG), .IW(SW)) u_pick (
      .en      (en),
      .cur     (cur_q),
      .nxt     (nxt),
      .has_next(has_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cur_q   <= '0;
         go_q    <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         flags_q <= '0;
      end else begin
         go_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (!busy_q) begin
            if (tile_start) begin
               flags_q <= live_m;
               if (live_key_ok) begin
                  busy_q <= 1'b1;
                  cur_q  <= stg_idx_t'(S_LOAD);
                  go_q   <= stg_vec_t'(1) << S_LOAD;
               end else begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end
            end
         end else if (stage_done[cur_q]) begin
            if (has_next) begin
               cur_q <= nxt;
               go_q  <= stg_vec_t'(1) << nxt;
            end else begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign stage_go  = go_q;
   assign busy      = busy_q;
   assign tile_done = done_q;
   assign cfg_err   = err_q;
endmodule

// File: rtl/tseq_checker.sv
module tseq_checker #(
   parameter logic [5:0] LAYER_PRESENT = 6'b111111
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tile_start,
   input logic [5:0] sel_flags,
   input logic [8:0] stage_done,
   input logic [8:0] stage_go,
   input logic       busy,
   input logic       tile_done,
   input logic       cfg_err
);
   logic start_key;
   assign start_key = |(sel_flags[2:0] & LAYER_PRESENT[2:0]);

   assert_go_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stage_go));

   assert_go_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_go != 9'd0) |=> (stage_go != $past(stage_go)));

   assert_hold_without_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stage_done == 9'd0) |=> (stage_go == 9'd0 && busy));

   assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tile_start && start_key) |=> (stage_go == 9'd1 && busy));

   assert_cfg_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tile_start && !start_key) |=> (tile_done && cfg_err && !busy && stage_go == 9'd0));

   assert_end_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> tile_done);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (stage_go == 9'd0));
endmodule

bind tile_stage_seq tseq_checker #(.LAYER_PRESENT(LAYER_PRESENT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tile_start(tile_start),
   .sel_flags (sel_flags),
   .stage_done(stage_done),
   .stage_go  (stage_go),
   .busy      (busy),
   .tile_done (tile_done),
   .cfg_err   (cfg_err)
);

// File: tb/tb_tile_stage_seq.sv
`timescale 1ns/1ps
module tb_tile_stage_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tile_start = 1'b0;
   logic [5:0] sel_flags = '0;
   logic [8:0] stage_done = '0;
   logic [8:0] stage_go;
   logic       busy, tile_done, cfg_err;

   logic       ts2 = 1'b0;
   logic [5:0] sel2 = '0;
   logic [8:0] done2 = '0;
   logic [8:0] go2;
   logic       busy2, tdone2, err2;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   tile_stage_seq dut (
      .clk(clk), .rst_n(rst_n), .tile_start(tile_start), .sel_flags(sel_flags),
      .stage_done(stage_done), .stage_go(stage_go), .busy(busy),
      .tile_done(tile_done), .cfg_err(cfg_err)
   );

   tile_stage_seq #(.LAYER_PRESENT(6'b111101)) dut_np (
      .clk(clk), .rst_n(rst_n), .tile_start(ts2), .sel_flags(sel2),
      .stage_done(done2), .stage_go(go2), .busy(busy2),
      .tile_done(tdone2), .cfg_err(err2)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] oh(input int s);
      return 9'(1) << s;
   endfunction

   task automatic run_tile(input logic [5:0] f);
      int seq [9];
      int n;
      string tag;
      @(negedge clk);
      tile_start = 1'b1; sel_flags = f; stage_done = '0;
      @(negedge clk);
      tile_start = 1'b0; sel_flags = ~f;  // R9: flags changed mid-tile
      if (f[2:0] == 3'b000) begin
         chk(tile_done && cfg_err && !busy && stage_go == 9'd0, "R7",
             {20'd0, tile_done, cfg_err, busy, stage_go}, {20'd0, 3'b110, 9'd0});
         @(negedge clk);
         chk(!tile_done && !cfg_err && !busy, "R7", {29'd0, tile_done, cfg_err, busy}, 32'd0);
         return;
      end
      n = 0;
      seq[n++] = 0;
      seq[n++] = f[0] ? 1 : (f[1] ? 2 : 3);
      if (f[3]) seq[n++] = 4;
      if (f[4]) seq[n++] = 5;
      if (f[5]) seq[n++] = 6;
      seq[n++] = 7;
      seq[n++] = 8;
      chk(stage_go == oh(0) && busy, "R1", {22'd0, busy, stage_go}, {22'd0, 1'b1, oh(0)});
      for (int k = 0; k < n; k++) begin
         // wrong-stage done bits and a stray start: both must be ignored (R5, R9)
         stage_done = ~oh(seq[k]);
         tile_start = 1'b1;
         @(negedge clk);
         chk(stage_go == 9'd0 && busy, "R5", {22'd0, busy, stage_go}, {22'd0, 1'b1, 9'd0});
         tile_start = 1'b0;
         stage_done = oh(seq[k]);
         @(negedge clk);
         stage_done = '0;
         if (k < n - 1) begin
            if (seq[k+1] <= 3)      tag = "R2";
            else if (seq[k+1] <= 6) tag = "R3";
            else                    tag = "R4";
            chk(stage_go == oh(seq[k+1]) && !tile_done, {tag, "/R6/R9"},
                {22'd0, tile_done, stage_go}, {22'd0, 1'b0, oh(seq[k+1])});
         end else begin
            chk(tile_done && !busy && !cfg_err && stage_go == 9'd0, "R4",
                {20'd0, tile_done, busy, cfg_err, stage_go}, {20'd0, 3'b100, 9'd0});
         end
      end
      @(negedge clk);
      chk(!tile_done && !busy, "R4", {30'd0, tile_done, busy}, 32'd0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(stage_go == 9'd0 && !busy && !tile_done && !cfg_err, "R10",
          {20'd0, busy, tile_done, cfg_err, stage_go}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stage_go == 9'd0 && !busy && !tile_done && !cfg_err, "R10",
          {20'd0, busy, tile_done, cfg_err, stage_go}, 32'd0);

      for (int f = 0; f < 64; f++) run_tile(6'(f));

      // R8: pooling absent in dut_np
      @(negedge clk);
      ts2 = 1'b1; sel2 = 6'b000010;
      @(negedge clk);
      ts2 = 1'b0;
      chk(tdone2 && err2 && go2 == 9'd0 && !busy2, "R8",
          {20'd0, tdone2, err2, busy2, go2}, {20'd0, 3'b110, 9'd0});
      @(negedge clk);
      ts2 = 1'b1; sel2 = 6'b010110;
      @(negedge clk);
      ts2 = 1'b0;
      chk(go2 == oh(0) && busy2, "R8", {23'd0, go2}, {23'd0, oh(0)});
      done2 = oh(0);
      @(negedge clk);
      done2 = '0;
      chk(go2 == oh(3), "R8", {23'd0, go2}, {23'd0, oh(3)});
      done2 = '1;
      @(negedge clk);
      chk(go2 == oh(5), "R8", {23'd0, go2}, {23'd0, oh(5)});
      repeat (3) @(negedge clk);
      done2 = '0;
      chk(!busy2 && tdone2, "R8", {30'd0, busy2, tdone2}, 32'd1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule